// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector Core

This block holds the digital part of an integer-N frequency synthesizer. A reference path divides incoming reference events by one of four ratios, all multiples of thirteen. A feedback path first halves the oscillator event stream and then divides it by a 9-bit programmable count. A phase-frequency detector compares the two divided streams and drives raise and lower requests toward an external charge pump.

Both sides work in one system clock domain. Each input is a one-cycle strobe per edge of the signal it represents. A configuration write stores the reference select and the main count. Each divider picks up a new value only at its next reload, so a period that is already running is never cut short. When the loop-power input is low, the detector is cleared and both pump outputs stay low.

Top module: `syn_divctl`

## Requirements
- R1: After reset, pump_up and pump_dn are low, the reference select is 2'b00 (divide by 13), and the main count is N_RESET (default 32). With events on every cycle, ref_tick therefore repeats every 13 cycles and fb_tick every 64 cycles.
- R2: cfg_ref_sel selects the reference ratio: 2'b00 = 13, 2'b01 = 26, 2'b10 = 39, 2'b11 = 52. ref_tick repeats once per that many ref_evt strobes.
- R3: The feedback path divides vco_evt by two before the main divider, so fb_tick repeats once per 2*N vco_evt strobes. With a strobe on every other cycle, that is 4*N cycles.
- R4: The main count N is 9 bits wide and covers every value from N_MIN (default 4) to 511.
- R5: A written main count below N_MIN (for example 0 or 2) behaves as N_MIN.
- R6: A configuration write changes a divider's ratio only at its next terminal count. The period in progress keeps the old ratio.
- R7: The cycle after a ref_tick, pump_up rises and holds while no fb_tick arrives. The cycle after an fb_tick, both pump outputs are low.
- R8: The cycle after an fb_tick, pump_dn rises and holds while no ref_tick arrives. The cycle after the next ref_tick, both pump outputs are low.
- R9: While pll_on is low, both pump outputs are low one cycle later and stay low whatever ticks arrive. Raising pll_on again leaves no stale request.
- R10: pump_up and pump_dn are never high in the same cycle.
- R11: ref_tick and fb_tick are each one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_ref_sel | input | 2 | Reference ratio select (13/26/39/52) |
| cfg_main_n | input | 9 | Main divider count N |
| pll_on | input | 1 | Loop power enable; low clears the detector |
| ref_evt | input | 1 | One-cycle strobe per reference edge |
| vco_evt | input | 1 | One-cycle strobe per oscillator edge |
| ref_tick | output | 1 | Divided reference pulse |
| fb_tick | output | 1 | Divided feedback pulse |
| pump_up | output | 1 | Raise request to the charge pump |
| pump_dn | output | 1 | Lower request to the charge pump |

## Verification
The bench measures tick periods after each write, so a wrong select encoding, a missing halving stage or an unclamped small N shows up as a wrong interval. It writes a new N right after a tick and checks that the running period keeps the old value. A design that reloads at once would give the new interval one period early. Directed detector sequences hold one side silent and check that the request stays asserted. They then check that the opposite tick clears both outputs instead of raising the other. They also drop pll_on while a request is pending and feed ticks while it is low, so a detector that keeps state through power-off is caught when pll_on returns.

// File: rtl/syn_pkg.sv
// Shared constants and helpers for the synthesizer divider core.
// Assumes the reference ratio is always a multiple of REF_UNIT.
package syn_pkg;

    localparam int REF_UNIT = 13;
    localparam int REF_W    = $clog2(REF_UNIT * 4 + 1);

    typedef enum logic [1:0] {
        REF_X1 = 2'b00,
        REF_X2 = 2'b01,
        REF_X3 = 2'b10,
        REF_X4 = 2'b11
    } ref_sel_e;

    // Map a select code to its reference ratio
    function automatic logic [REF_W-1:0] ref_ratio(input ref_sel_e s);
        case (s)
            REF_X1:  return REF_W'(REF_UNIT);
            REF_X2:  return REF_W'(REF_UNIT * 2);
            REF_X3:  return REF_W'(REF_UNIT * 3);
            default: return REF_W'(REF_UNIT * 4);
        endcase
    endfunction

endpackage

// File: rtl/syn_prescale.sv
// Fixed divide-by-two on the oscillator event stream.
// Emits a one-cycle registered pulse on every second input strobe.
// Assumes evt is a one-cycle strobe per oscillator edge.
module syn_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic half_evt
);

    logic phase_q;

    // Toggle phase per strobe; fire on the second of each pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= 1'b0;
            half_evt <= 1'b0;
        end else begin
            half_evt <= evt & phase_q;
            if (evt) phase_q <= ~phase_q;
        end
    end

    a_r3_half_single : assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |=> !half_evt);

endmodule

// File: rtl/syn_counter.sv
// Programmable event divider. Counts input strobes and emits one
// registered pulse per RATIO strobes. The ratio is sampled from `load`
// only at terminal count, and values below MIN_LOAD are raised to it.
// Assumes MIN_LOAD >= 2 so output pulses never touch.
module syn_counter #(
    parameter int W        = 9,
    parameter int RST_LOAD = 13,
    parameter int MIN_LOAD = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic [W-1:0] load,
    output logic         tc
);

    localparam logic [W-1:0] MIN_V = W'(MIN_LOAD);
    localparam logic [W-1:0] RST_V = W'(RST_LOAD);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] eff;
    logic         last;

    // Clamp the requested ratio to the floor
    always_comb begin
        eff  = (load < MIN_V) ? MIN_V : load;
        last = (cnt_q == cur_q - 1'b1);
    end

    // Count strobes, reload ratio and pulse at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= RST_V;
            tc    <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (evt) begin
                if (last) begin
                    cnt_q <= '0;
                    cur_q <= eff;
                    tc    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    a_r11_tc_single : assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    a_r5_ratio_floor : assert property (@(posedge clk) disable iff (!rst_n)
        cur_q >= MIN_V);
    a_r6_ratio_held : assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cur_q));

endmodule

// File: rtl/syn_pfd.sv
// Phase-frequency detector built from two request flops. A reference
// pulse sets the up flop and a feedback pulse sets the down flop. When
// both would be set, both clear. Low pll_on clears and holds both.
// Assumes single-cycle input pulses in the same clock domain.
module syn_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_on,
    input  logic ref_p,
    input  logic fb_p,
    output logic up_q,
    output logic dn_q
);

    logic nxt_up;
    logic nxt_dn;
    logic both;

    // Candidate next state before the mutual clear
    always_comb begin
        nxt_up = up_q | ref_p;
        nxt_dn = dn_q | fb_p;
        both   = nxt_up & nxt_dn;
    end

    // Hold requests, clearing on coincidence or power-off
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_on || both) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= nxt_up;
            dn_q <= nxt_dn;
        end
    end

    a_r10_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
        !(up_q && dn_q));
    a_r9_off_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |=> (!up_q && !dn_q));
    a_r7_up_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_q) |-> $past(ref_p));
    a_r8_dn_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_q) |-> $past(fb_p));

endmodule

// File: rtl/syn_divctl.sv
// Top of the synthesizer divider core. Holds the configuration
// register and chains the reference divider, the divide-by-two stage,
// the main divider and the phase-frequency detector.
// Assumes all event inputs are one-cycle strobes on clk.
module syn_divctl #(
    parameter int N_W     = 9,
    parameter int N_MIN   = 4,
    parameter int N_RESET = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [1:0]     cfg_ref_sel,
    input  logic [N_W-1:0] cfg_main_n,
    input  logic           pll_on,
    input  logic           ref_evt,
    input  logic           vco_evt,
    output logic           ref_tick,
    output logic           fb_tick,
    output logic           pump_up,
    output logic           pump_dn
);
    import syn_pkg::*;

    localparam int N_RST_EFF = (N_RESET < N_MIN) ? N_MIN : N_RESET;

    ref_sel_e         sel_q;
    logic [N_W-1:0]   n_q;
    logic [REF_W-1:0] ref_load;
    logic             half_evt;

    // Configuration register with documented defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= REF_X1;
            n_q   <= N_W'(N_RESET);
        end else if (cfg_wr) begin
            sel_q <= ref_sel_e'(cfg_ref_sel);
            n_q   <= cfg_main_n;
        end
    end

    // Translate the select field into a reference ratio
    always_comb ref_load = ref_ratio(sel_q);

    syn_counter #(
        .W(REF_W), .RST_LOAD(REF_UNIT), .MIN_LOAD(REF_UNIT)
    ) u_refdiv (
        .clk(clk), .rst_n(rst_n), .evt(ref_evt), .load(ref_load), .tc(ref_tick)
    );

    syn_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .evt(vco_evt), .half_evt(half_evt)
    );

    syn_counter #(
        .W(N_W), .RST_LOAD(N_RST_EFF), .MIN_LOAD(N_MIN)
    ) u_maindiv (
        .clk(clk), .rst_n(rst_n), .evt(half_evt), .load(n_q), .tc(fb_tick)
    );

    syn_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .pll_on(pll_on),
        .ref_p(ref_tick), .fb_p(fb_tick), .up_q(pump_up), .dn_q(pump_dn)
    );

    a_r1_idle_after_reset : assert property (@(posedge clk)
        !rst_n |=> (!pump_up && !pump_dn && !ref_tick && !fb_tick));

endmodule

// File: tb/sim_syn_divctl.sv
`timescale 1ns/1ps
module sim_syn_divctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_ref_sel = 2'b00;
    logic [8:0] cfg_main_n = 9'd0;
    logic       pll_on = 1'b0;
    logic       ref_evt = 1'b0;
    logic       vco_evt = 1'b0;
    logic       ref_tick, fb_tick, pump_up, pump_dn;

    int ref_mode = 0;
    int vco_mode = 0;
    logic ph = 1'b0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    syn_divctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ref_sel(cfg_ref_sel),
        .cfg_main_n(cfg_main_n), .pll_on(pll_on), .ref_evt(ref_evt),
        .vco_evt(vco_evt), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .pump_up(pump_up), .pump_dn(pump_dn)
    );

    // Event stimulus: mode 0 off, 1 every cycle, 2 every other cycle
    always @(posedge clk) begin
        #1;
        ph = ~ph;
        ref_evt = (ref_mode == 1) || (ref_mode == 2 && ph);
        vco_evt = (vco_mode == 1) || (vco_mode == 2 && ph);
    end

    // {sel, N, expected ref period, expected fb period}
    localparam logic [31:0] VEC [6] = '{
        {2'd0, 9'd100, 10'd13, 11'd200},
        {2'd1, 9'd4,   10'd26, 11'd8},
        {2'd2, 9'd511, 10'd39, 11'd1022},
        {2'd3, 9'd2,   10'd52, 11'd8},
        {2'd0, 9'd0,   10'd13, 11'd8},
        {2'd3, 9'd257, 10'd52, 11'd514}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick(input bit fb, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!(fb ? fb_tick : ref_tick) && cyc < 6000);
    endtask

    task automatic cfg(input logic [1:0] s, input logic [8:0] n);
        cfg_ref_sel = s;
        cfg_main_n = n;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Skip the reload tick, then return the next full period
    task automatic period(input bit fb, output int cyc);
        int c;
        wait_tick(fb, c);
        wait_tick(fb, cyc);
    endtask

    initial begin
        int c, c2;
        repeat (3) @(negedge clk);
        check(!pump_up && !pump_dn && !ref_tick && !fb_tick, "R1 reset idle", 0, 0);
        rst_n = 1'b1;
        pll_on = 1'b1;
        ref_mode = 1;
        vco_mode = 1;
        wait_tick(0, c);
        wait_tick(0, c);
        check(c == 13, "R1 default ref period", c, 13);
        period(1, c);
        check(c == 64, "R1 default fb period", c, 64);

        // Table of ratio settings: R2 R3 R4 R5 R11
        for (int i = 0; i < 6; i++) begin
            cfg(VEC[i][31:30], VEC[i][29:21]);
            @(negedge clk);
            period(0, c);
            check(c == int'(VEC[i][20:11]), "R2 ref period", c, int'(VEC[i][20:11]));
            @(negedge clk);
            check(!ref_tick, "R11 ref tick width", int'(ref_tick), 0);
            period(1, c);
            check(c == int'(VEC[i][10:0]), "R4 R5 fb period", c, int'(VEC[i][10:0]));
            @(negedge clk);
            check(!fb_tick, "R11 fb tick width", int'(fb_tick), 0);
        end

        // R6: write just after a tick; running period keeps old ratio
        cfg(2'd0, 9'd100);
        @(negedge clk);
        period(1, c);
        wait_tick(1, c);
        cfg(2'd0, 9'd20);
        wait_tick(1, c2);
        check(c2 + 1 == 200, "R6 old ratio kept", c2 + 1, 200);
        wait_tick(1, c);
        check(c == 40, "R6 new ratio at reload", c, 40);

        // R3: strobes on every other cycle double the periods
        cfg(2'd0, 9'd10);
        ref_mode = 2;
        vco_mode = 2;
        @(negedge clk);
        period(1, c);
        check(c == 40, "R3 halved vco stream", c, 40);
        period(0, c);
        check(c == 26, "R2 ref on sparse strobes", c, 26);

        // Detector tests: stop events and clear the detector
        ref_mode = 0;
        vco_mode = 0;
        repeat (3) @(negedge clk);
        pll_on = 1'b0;
        repeat (2) @(negedge clk);
        pll_on = 1'b1;
        @(negedge clk);
        check(!pump_up && !pump_dn, "R9 cleared before detector tests", int'(pump_up), 0);

        // R7: up holds until feedback arrives
        ref_mode = 1;
        wait_tick(0, c);
        ref_mode = 0;
        @(negedge clk);
        check(pump_up && !pump_dn, "R7 up after ref tick", int'(pump_up), 1);
        repeat (5) @(negedge clk);
        check(pump_up && !pump_dn, "R7 up holds", int'(pump_up), 1);
        vco_mode = 1;
        wait_tick(1, c);
        vco_mode = 0;
        @(negedge clk);
        check(!pump_up && !pump_dn, "R7 fb clears both", int'(pump_up) + int'(pump_dn), 0);

        // R8: down holds until reference arrives
        vco_mode = 1;
        wait_tick(1, c);
        vco_mode = 0;
        @(negedge clk);
        check(pump_dn && !pump_up, "R8 dn after fb tick", int'(pump_dn), 1);
        repeat (4) @(negedge clk);
        check(pump_dn && !pump_up, "R8 dn holds", int'(pump_dn), 1);
        ref_mode = 1;
        wait_tick(0, c);
        ref_mode = 0;
        @(negedge clk);
        check(!pump_up && !pump_dn, "R8 ref clears both", int'(pump_up) + int'(pump_dn), 0);

        // R9: power-off clears a pending request and blocks new ones
        vco_mode = 1;
        wait_tick(1, c);
        vco_mode = 0;
        @(negedge clk);
        check(pump_dn, "R9 dn pending", int'(pump_dn), 1);
        pll_on = 1'b0;
        @(negedge clk);
        check(!pump_dn && !pump_up, "R9 off clears", int'(pump_dn), 0);
        vco_mode = 1;
        wait_tick(1, c);
        vco_mode = 0;
        @(negedge clk);
        check(!pump_dn, "R9 fb ignored while off", int'(pump_dn), 0);
        ref_mode = 1;
        wait_tick(0, c);
        ref_mode = 0;
        @(negedge clk);
        check(!pump_up, "R9 ref ignored while off", int'(pump_up), 0);
        repeat (3) @(negedge clk);
        pll_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!pump_up && !pump_dn, "R9 R10 no stale request", int'(pump_up) + int'(pump_dn), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule